// File: doc/BRIEF.md
# Eye-Closure Percentage Monitor

This block tracks how much of the recent past a driver spent with eyes judged closed. An upstream detector hands it one result per processed frame over a valid/ready stream: an eye-open flag. Each accepted frame becomes one entry in a circular history. The entry holds the tick at which it arrived, the number of ticks since the previous entry, and whether the eyes were closed. That duration is the weight the frame carries. A prescaled free-running tick counter supplies the timestamps.

Two running totals are kept: all weighted time in the window, and the closed-eye part of it. They change when a frame is added and when an entry leaves. An entry leaves when it ages past the window length, or when the history is full and a new frame overwrites the oldest slot. From the totals the block computes an integer closure percentage for display. Separately, every cycle, it evaluates the alarm condition `100*closed > 15*total`. The alarm is suppressed until the window holds a minimum amount of time.

A clear request empties the history, zeroes the totals and the tick counter, and drops the outputs. Stream rule: a frame transfers on a cycle where `frm_valid_i` and `frm_ready_o` are both high. Ready is low only in cycles where `clear_i` is high. A producer may keep valid asserted across such a cycle, and the frame is then taken on the next cycle with ready high.

Top module: `pcl_monitor`

## Requirements
- R1: The tick counter starts at 0 after reset or clear and advances by exactly one every CLK_PER_TICK clock cycles. Timestamps and durations are counted in these ticks.
- R2: A frame is accepted only on a cycle with frm_valid_i=1 and frm_ready_o=1. frm_ready_o is 0 exactly in cycles with clear_i=1, and a frame offered in such a cycle has no effect on the totals.
- R3: An accepted frame's duration is the current tick minus the tick of the previous accepted frame, or minus 0 for the first frame after clear. The frame counts as closed when frm_open_i=0 and as open when frm_open_i=1. The duration is added to the total time, and also to the closed time when the frame is closed.
- R4: An entry whose timestamp is more than WINDOW_TICKS ticks older than the current tick is removed, and its duration leaves both totals. At most one entry is removed per cycle.
- R5: When DEPTH entries are held and a frame is accepted, the oldest entry is overwritten and its duration leaves both totals. The entry count never exceeds DEPTH.
- R6: closure_pct_o is floor(100*closed/total), or 0 when total is 0. It settles within 10 cycles of the last change to the totals and never exceeds 100.
- R7: alarm_o is re-evaluated every cycle from the totals of the previous cycle. It is 1 only when total >= MIN_TICKS and 100*closed > ALARM_PCT*total, where ALARM_PCT defaults to 15. An exactly-equal comparison gives 0.
- R8: clear_i empties the history and zeroes both totals and the tick counter. On the next cycle it forces closure_pct_o and alarm_o to 0.
- R9: When a frame is accepted in the same cycle that an entry is removed, whether by age or by overwrite, both updates apply together in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Clear history, totals and tick counter |
| frm_valid_i | input | 1 | A frame result is offered |
| frm_ready_o | output | 1 | Frame can be taken this cycle |
| frm_open_i | input | 1 | 1 = eyes detected open, 0 = closed |
| closure_pct_o | output | 7 | Closed-eye percentage of the window, 0..100 |
| alarm_o | output | 1 | Closure above threshold |

## Verification
The delicate case is a frame push that lands in the same cycle as a removal. The removal may come from the age limit or from overwriting a full history. The bench provokes the age case by placing a frame exactly on the tick at which the oldest entry first exceeds the window. It provokes the overwrite case by streaming more frames than the history holds. In both cases the bench judges the result by comparing the percentage and alarm with its own entry list. That list applies the removal first and then the push, so a dropped update or a doubled removal shows up as a wrong percentage.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  localparam int unsigned PCT_W     = 7;
  localparam int unsigned PCT_SCALE = 100;
  typedef logic [PCT_W-1:0] pct_t;
endpackage

// File: rtl/pcl_timebase.sv
module pcl_timebase #(
  parameter int unsigned CLK_PER_TICK = 250000,
  parameter int unsigned TIME_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  output logic [TIME_W-1:0] now_o
);
  logic [TIME_W-1:0] now_q;

  generate
    if (CLK_PER_TICK <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     now_q <= '0;
        else if (clr_i) now_q <= '0;
        else            now_q <= now_q + 1'b1;
      end
    end else begin : g_presc
      localparam int unsigned PW = $clog2(CLK_PER_TICK);
      localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_TICK - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
          now_q <= '0;
        end else if (clr_i) begin
          pre_q <= '0;
          now_q <= '0;
        end else if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          now_q <= now_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  endgenerate

  assign now_o = now_q;

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (now_o == $past(now_o) || now_o == $past(now_o) + 1'b1));

  assert_tick_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> now_o == '0);
endmodule

// File: rtl/pcl_history.sv
module pcl_history #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned TIME_W = 32,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [TIME_W-1:0] wr_ts_i,
  input  logic [TIME_W-1:0] wr_dur_i,
  input  logic              wr_closed_i,
  output logic [TIME_W-1:0] head_ts_o,
  output logic [TIME_W-1:0] head_dur_o,
  output logic              head_closed_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [TIME_W-1:0] ts_mem  [DEPTH];
  logic [TIME_W-1:0] dur_mem [DEPTH];
  logic [DEPTH-1:0]  cl_mem;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) begin
      ts_mem[wr_ptr]  <= wr_ts_i;
      dur_mem[wr_ptr] <= wr_dur_i;
      cl_mem[wr_ptr]  <= wr_closed_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (clr_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      unique case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_ts_o     = ts_mem[rd_ptr];
  assign head_dur_o    = dur_mem[rd_ptr];
  assign head_closed_o = cl_mem[rd_ptr];
  assign count_o       = count_q;
  assign full_o        = (count_q == CW'(DEPTH));
  assign empty_o       = (count_q == '0);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  assert_full_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !clr_i) |=> full_o);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pcl_ratio_div.sv
module pcl_ratio_div
  import pcl_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  localparam int unsigned NUM_W = TIME_W + PCT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [TIME_W-1:0] den_i,
  output pct_t              q_o
);
  localparam int unsigned SW = $clog2(PCT_W);

  logic             busy_q;
  logic [SW-1:0]    step_q;
  logic [NUM_W-1:0] rem_q, den_q, trial;
  pct_t             acc_q, acc_n;
  logic             fits;

  always_comb begin
    trial        = den_q << step_q;
    fits         = (rem_q >= trial);
    acc_n        = acc_q;
    acc_n[step_q] = fits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      acc_q  <= '0;
      q_o    <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      acc_q  <= '0;
      q_o    <= '0;
    end else if (start_i) begin
      if (den_i == '0) begin
        busy_q <= 1'b0;
        q_o    <= '0;
      end else begin
        busy_q <= 1'b1;
        step_q <= SW'(PCT_W - 1);
        rem_q  <= num_i;
        den_q  <= NUM_W'(den_i);
        acc_q  <= '0;
      end
    end else if (busy_q) begin
      if (fits) rem_q <= rem_q - trial;
      acc_q <= acc_n;
      if (step_q == '0) begin
        q_o    <= acc_n;
        busy_q <= 1'b0;
      end else begin
        step_q <= step_q - 1'b1;
      end
    end
  end

  assert_pct_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_o <= pct_t'(PCT_SCALE));
endmodule

// File: rtl/pcl_monitor.sv
module pcl_monitor
  import pcl_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 250000,
  parameter int unsigned WINDOW_TICKS = 60000,
  parameter int unsigned MIN_TICKS    = 1000,
  parameter int unsigned ALARM_PCT    = 15,
  parameter int unsigned DEPTH        = 256,
  parameter int unsigned TIME_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             frm_valid_i,
  output logic             frm_ready_o,
  input  logic             frm_open_i,
  output logic [PCT_W-1:0] closure_pct_o,
  output logic             alarm_o
);
  localparam int unsigned NUM_W = TIME_W + PCT_W;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic [TIME_W-1:0] now, last_ts, dur, age;
  logic [TIME_W-1:0] head_ts, head_dur;
  logic [TIME_W-1:0] total_q, closed_q, total_n, closed_n;
  logic [NUM_W-1:0]  closed_scaled, total_scaled;
  logic [CW-1:0]     count;
  logic head_cl, full, empty, push, pop, stale, upd_q, alarm_q;

  pcl_timebase #(.CLK_PER_TICK(CLK_PER_TICK), .TIME_W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .now_o(now));

  assign frm_ready_o = ~clear_i;
  assign push        = frm_valid_i & frm_ready_o;
  assign dur         = now - last_ts;
  assign age         = now - head_ts;
  assign stale       = ~empty & (age > TIME_W'(WINDOW_TICKS));
  assign pop         = ~clear_i & (stale | (full & push));

  pcl_history #(.DEPTH(DEPTH), .TIME_W(TIME_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i),
    .push_i(push), .pop_i(pop),
    .wr_ts_i(now), .wr_dur_i(dur), .wr_closed_i(~frm_open_i),
    .head_ts_o(head_ts), .head_dur_o(head_dur), .head_closed_o(head_cl),
    .count_o(count), .full_o(full), .empty_o(empty));

  always_comb begin
    total_n  = total_q;
    closed_n = closed_q;
    if (push) begin
      total_n = total_n + dur;
      if (!frm_open_i) closed_n = closed_n + dur;
    end
    if (pop) begin
      total_n = total_n - head_dur;
      if (head_cl) closed_n = closed_n - head_dur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q  <= '0;
      closed_q <= '0;
      last_ts  <= '0;
      upd_q    <= 1'b0;
    end else if (clear_i) begin
      total_q  <= '0;
      closed_q <= '0;
      last_ts  <= '0;
      upd_q    <= 1'b0;
    end else begin
      total_q  <= total_n;
      closed_q <= closed_n;
      if (push) last_ts <= now;
      upd_q    <= push | pop;
    end
  end

  assign closed_scaled = NUM_W'(closed_q) * NUM_W'(PCT_SCALE);
  assign total_scaled  = NUM_W'(total_q) * NUM_W'(ALARM_PCT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alarm_q <= 1'b0;
    else if (clear_i) alarm_q <= 1'b0;
    else              alarm_q <= (total_q >= TIME_W'(MIN_TICKS)) &&
                                 (closed_scaled > total_scaled);
  end
  assign alarm_o = alarm_q;

  pcl_ratio_div #(.TIME_W(TIME_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .start_i(upd_q),
    .num_i(closed_scaled), .den_i(total_q), .q_o(closure_pct_o));

  assert_closed_le_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
    closed_q <= total_q);

  assert_age_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && !push && !clear_i) |=> count == $past(count) - 1'b1);

  assert_alarm_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> $past(total_q >= TIME_W'(MIN_TICKS)));

  assert_clear_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!alarm_o && closure_pct_o == '0 && total_q == '0 && count == '0));

  assert_push_pop_net_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> count == $past(count));
endmodule

// File: tb/tb_pcl_monitor.sv
`timescale 1ns/1ps
module tb_pcl_monitor;
  localparam int CPT   = 2;
  localparam int WIN   = 100;
  localparam int MINT  = 30;
  localparam int APCT  = 15;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic frm_valid = 1'b0;
  logic frm_open = 1'b1;
  logic frm_ready;
  logic [6:0] pct;
  logic alarm;

  always #2 clk = ~clk;

  pcl_monitor #(.CLK_PER_TICK(CPT), .WINDOW_TICKS(WIN), .MIN_TICKS(MINT),
                .ALARM_PCT(APCT), .DEPTH(DEPTH), .TIME_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .frm_valid_i(frm_valid),
    .frm_ready_o(frm_ready), .frm_open_i(frm_open),
    .closure_pct_o(pct), .alarm_o(alarm));

  int tb_cyc = 0;
  always @(posedge clk) begin
    if (!rst_n || clear) tb_cyc <= 0;
    else                 tb_cyc <= tb_cyc + 1;
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_ts [64];
  int m_d  [64];
  bit m_cl [64];
  int m_n = 0;
  int m_last = 0;

  function automatic int now_tick();
    return tb_cyc / CPT;
  endfunction

  task automatic m_drop();
    for (int i = 1; i < m_n; i++) begin
      m_ts[i-1] = m_ts[i];
      m_d[i-1]  = m_d[i];
      m_cl[i-1] = m_cl[i];
    end
    m_n--;
  endtask

  task automatic m_expire(input int now);
    while (m_n > 0 && (now - m_ts[0]) > WIN) m_drop();
  endtask

  task automatic expect_eq(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // at a negedge: offer one frame and update the model
  task automatic push_here(input string req, input bit open);
    int now = now_tick();
    m_expire(now);
    if (m_n == DEPTH) m_drop();
    m_ts[m_n] = now;
    m_d[m_n]  = now - m_last;
    m_cl[m_n] = !open;
    m_n++;
    m_last = now;
    frm_valid = 1'b1;
    frm_open  = open;
    expect_eq(req, "ready", int'(frm_ready), 1);
    @(posedge clk);
    #1 frm_valid = 1'b0;
  endtask

  task automatic push_at(input string req, input int tick, input bit open);
    @(negedge clk);
    while (now_tick() < tick) @(negedge clk);
    push_here(req, open);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check_out(input string req);
    int tot = 0;
    int cls = 0;
    int ep, ea;
    @(negedge clk);
    m_expire(now_tick());
    for (int i = 0; i < m_n; i++) begin
      tot += m_d[i];
      if (m_cl[i]) cls += m_d[i];
    end
    ep = (tot == 0) ? 0 : (cls * 100) / tot;
    ea = (tot >= MINT && cls * 100 > APCT * tot) ? 1 : 0;
    expect_eq(req, "pct", int'(pct), ep);
    expect_eq(req, "alarm", int'(alarm), ea);
  endtask

  task automatic do_clear(input bit offer_frame);
    @(negedge clk);
    clear = 1'b1;
    frm_valid = offer_frame;
    frm_open = 1'b0;
    m_n = 0;
    m_last = 0;
    #0.5;
    expect_eq("R2", "ready_in_clear", int'(frm_ready), 0);
    @(posedge clk);
    #1 clear = 1'b0;
    frm_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_eq("R8", "reset_pct", int'(pct), 0);
    expect_eq("R8", "reset_alarm", int'(alarm), 0);
    expect_eq("R2", "reset_ready", int'(frm_ready), 1);
  endtask

  task automatic t_all_open();
    do_clear(1'b0);
    push_at("R3", 10, 1'b1);
    push_at("R3", 25, 1'b1);
    push_at("R3", 40, 1'b1);
    wait_cycles(14);
    check_out("R3_all_open");
  endtask

  task automatic t_ticks();
    do_clear(1'b0);
    push_at("R1", 20, 1'b0);
    push_at("R1", 80, 1'b1);
    wait_cycles(14);
    check_out("R1_durations");
    expect_eq("R1", "pct_25", int'(pct), 25);
  endtask

  task automatic t_min_time();
    do_clear(1'b0);
    push_at("R7", 20, 1'b0);
    wait_cycles(12);
    check_out("R7_below_min");
    push_at("R7", 30, 1'b0);
    wait_cycles(14);
    check_out("R7_at_min");
    expect_eq("R7", "alarm_at_min", int'(alarm), 1);
  endtask

  task automatic t_threshold();
    do_clear(1'b0);
    push_at("R7", 15, 1'b0);
    push_at("R7", 100, 1'b1);
    wait_cycles(14);
    check_out("R7_equal_15");
    expect_eq("R7", "alarm_equal", int'(alarm), 0);
    do_clear(1'b0);
    push_at("R7", 16, 1'b0);
    push_at("R7", 100, 1'b1);
    wait_cycles(14);
    check_out("R7_above_15");
    expect_eq("R6", "pct_16", int'(pct), 16);
  endtask

  task automatic t_expiry();
    do_clear(1'b0);
    push_at("R4", 10, 1'b0);
    push_at("R4", 50, 1'b1);
    wait_cycles(14);
    check_out("R4_before_age");
    @(negedge clk);
    while (now_tick() < 125) @(negedge clk);
    check_out("R4_after_age");
    expect_eq("R4", "pct_after_age", int'(pct), 0);
  endtask

  task automatic t_same_cycle();
    do_clear(1'b0);
    push_at("R9", 10, 1'b0);
    push_at("R9", 60, 1'b0);
    push_at("R9", 111, 1'b1);
    wait_cycles(14);
    check_out("R9_push_with_age");
    expect_eq("R9", "pct_49", int'(pct), 49);
  endtask

  task automatic t_full();
    do_clear(1'b0);
    for (int k = 1; k <= 12; k++) push_at("R5", 4 * k, (k % 2) == 0);
    wait_cycles(14);
    check_out("R5_overwrite");
    expect_eq("R5", "pct_50", int'(pct), 50);
  endtask

  task automatic t_clear();
    do_clear(1'b1);
    @(negedge clk);
    expect_eq("R8", "pct_after_clear", int'(pct), 0);
    expect_eq("R8", "alarm_after_clear", int'(alarm), 0);
    push_at("R2", 40, 1'b1);
    wait_cycles(14);
    check_out("R2_ignored_in_clear");
    push_at("R8", 60, 1'b0);
    wait_cycles(14);
    check_out("R8_restart");
    expect_eq("R6", "pct_33", int'(pct), 33);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_open();
    t_ticks();
    t_min_time();
    t_threshold();
    t_expiry();
    t_same_cycle();
    t_full();
    t_clear();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule